// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a fully associative cache of virtual-to-physical page translations. Each slot holds a virtual page number, a 16-bit address-space tag, a physical page number, a two-bit page-level field and the leaf permission bits of the page-table entry. A page walker outside the block fills slots after a miss. Address-space fences invalidate slots by page, by address space or both. A lookup port returns the physical address and the stored permission bits one cycle after the request. The block only stores the permission bits and hands them back unchanged. It never interprets them.

Each cycle the block performs at most one operation. The operation decoder produces one of four named operations: OP_IDLE, OP_LOOKUP, OP_INSERT and OP_FLUSH. It picks OP_FLUSH when a fence is requested. Otherwise it picks OP_INSERT when a fill is requested, otherwise OP_LOOKUP when a lookup is requested, and OP_IDLE when nothing is requested. The decoded operation is registered every cycle. A registered OP_LOOKUP raises the response-valid output. From any operation the next cycle may go to any other; no operation ever stalls.

Slots are replaced least-recently-used. A global sequence counter stamps a slot each time the slot is filled or hit by a visible lookup. Read and write lookups each have a hit counter and a miss counter, and the block also reports their sums. A lookup marked hidden returns its translation but leaves the stamps and the counters untouched.

Top module: `xlt_cache`

## Requirements
- R1: A lookup hits when a valid slot has an equal address-space tag and an equal virtual page number, compared above the slot's page level. One cycle later the response shows valid=1 and hit=1. The physical address on the response is {slot PPN OR (lookup VPN bits below the page level), lookup page offset[11:0]}, and the response also carries the slot's permission byte. A lookup carrying another tag misses. When several slots match, the lowest-numbered slot answers.
- R2: The level field sets how many low VPN bits a slot ignores: level L ignores the low 9*L bits (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB). Any address inside the page hits.
- R3: Requests are served in the priority fence, then fill, then lookup. Only a lookup that is served raises the response valid in the next cycle.
- R4: A fill whose tag, level and masked VPN equal those of a valid slot replaces only that slot's permission byte. The fill takes no other slot.
- R5: A fill takes the lowest-numbered invalid slot before it evicts any valid slot.
- R6: When every slot is valid, a fill evicts the slot with the oldest stamp. The sequence counter stamps a slot on each fill and on each visible hit.
- R7: A fence invalidates every valid slot that matches it. A fence VPN of zero matches any page, and a fence tag of zero matches any tag. Slots that do not match stay intact.
- R8: A fence compares addresses using each slot's own page level, so any VPN inside a superpage removes that superpage.
- R9: A visible lookup with write=1 increments the write hit counter or the write miss counter; with write=0 it increments the read hit counter or the read miss counter. The total outputs are the hit sum, the miss sum and their sum.
- R10: A hidden lookup returns the same response as a visible one but changes neither the counters nor any stamp.
- R11: After reset all slots are invalid, all counters are zero and response valid is 0. A miss response gives hit=0, an address of 0 and a permission byte of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 39 | Lookup virtual address (VPN in bits 38:12) |
| lk_asid | input | 16 | Lookup address-space tag |
| lk_write | input | 1 | Lookup is a write access |
| lk_hidden | input | 1 | Lookup leaves the stamps and the counters alone |
| ins_valid | input | 1 | Fill request |
| ins_vpn | input | 27 | Fill virtual page number |
| ins_asid | input | 16 | Fill address-space tag |
| ins_ppn | input | 28 | Fill physical page number, aligned to its level |
| ins_level | input | 2 | Fill page level |
| ins_pte | input | 8 | Fill leaf permission bits |
| fl_valid | input | 1 | Fence request |
| fl_vpn | input | 27 | Fence VPN, zero matches any page |
| fl_asid | input | 16 | Fence tag, zero matches any tag |
| rsp_valid | output | 1 | Response to the lookup of the previous cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 40 | Translated physical address |
| rsp_pte | output | 8 | Stored permission bits |
| cnt_rd_hit | output | 16 | Read hits |
| cnt_rd_miss | output | 16 | Read misses |
| cnt_wr_hit | output | 16 | Write hits |
| cnt_wr_miss | output | 16 | Write misses |
| cnt_hit_total | output | 17 | Read plus write hits |
| cnt_miss_total | output | 17 | Read plus write misses |
| cnt_access_total | output | 18 | All visible lookups |

## Verification
A wrong stamp, a wrong slot choice or a wrong valid bit cannot be seen right away. The first sign is a miss on a later lookup to a page that should still be cached, or a hit on a page that should have been evicted or fenced. That lookup may come many fills later. A wrong match mask shows on the very next lookup inside a superpage, either as a false miss or as wrong low bits in the physical address. A counter fault shows on the cycle after the lookup that caused it. For these reasons the bench keeps its own copy of the slots, stamps and counters. It compares every response and every counter after every operation, so a wrong state is reported on the first lookup that can expose it.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    // Operation served in a cycle, in priority order fence > fill > lookup
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_INSERT = 2'd2,
        OP_FLUSH  = 2'd3
    } xlt_op_e;

endpackage

// File: rtl/xlt_match.sv
module xlt_match #(
    parameter int N        = 8,
    parameter int VPN_W    = 27,
    parameter int ASID_W   = 16,
    parameter int LVL_W    = 2,
    parameter int LVL_BITS = 9
) (
    input  logic [N-1:0]              ent_valid,
    input  logic [N-1:0][VPN_W-1:0]   ent_vpn,
    input  logic [N-1:0][ASID_W-1:0]  ent_asid,
    input  logic [N-1:0][LVL_W-1:0]   ent_lvl,
    input  logic [VPN_W-1:0]          q_vpn,
    input  logic [ASID_W-1:0]         q_asid,
    input  logic [LVL_W-1:0]          q_lvl,
    input  logic                      any_vpn,
    input  logic                      any_asid,
    input  logic                      same_lvl,
    output logic [N-1:0]              hit
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic [VPN_W-1:0] keep;
        logic             tag_ok;
        logic             page_ok;
        logic             lvl_ok;

        // bits above the slot's page level take part in the compare
        assign keep    = {VPN_W{1'b1}} << (LVL_BITS * int'(ent_lvl[i]));
        assign tag_ok  = any_asid || (ent_asid[i] == q_asid);
        assign page_ok = any_vpn || (((ent_vpn[i] ^ q_vpn) & keep) == '0);
        assign lvl_ok  = !same_lvl || (ent_lvl[i] == q_lvl);
        assign hit[i]  = ent_valid[i] && tag_ok && page_ok && lvl_ok;
    end

endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
    parameter int N     = 8,
    parameter int SEQ_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0][SEQ_W-1:0]  ent_stamp,
    output logic [IDX_W-1:0]         victim
);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;
    logic [SEQ_W-1:0] old_stamp;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!ent_valid[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        // strict compare keeps the lowest index on equal stamps
        old_idx   = '0;
        old_stamp = ent_stamp[0];
        for (int i = 1; i < N; i++) begin
            if (ent_stamp[i] < old_stamp) begin
                old_stamp = ent_stamp[i];
                old_idx   = IDX_W'(i);
            end
        end
        victim = free_found ? free_idx : old_idx;
    end

endmodule

// File: rtl/xlt_counters.sv
module xlt_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             is_write,
    input  logic             was_hit,
    output logic [CNT_W-1:0] cnt_rd_hit,
    output logic [CNT_W-1:0] cnt_rd_miss,
    output logic [CNT_W-1:0] cnt_wr_hit,
    output logic [CNT_W-1:0] cnt_wr_miss,
    output logic [CNT_W:0]   cnt_hit_total,
    output logic [CNT_W:0]   cnt_miss_total,
    output logic [CNT_W+1:0] cnt_access_total
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_rd_hit  <= '0;
            cnt_rd_miss <= '0;
            cnt_wr_hit  <= '0;
            cnt_wr_miss <= '0;
        end else if (count_en) begin
            unique case ({is_write, was_hit})
                2'b00:   cnt_rd_miss <= cnt_rd_miss + 1'b1;
                2'b01:   cnt_rd_hit  <= cnt_rd_hit + 1'b1;
                2'b10:   cnt_wr_miss <= cnt_wr_miss + 1'b1;
                default: cnt_wr_hit  <= cnt_wr_hit + 1'b1;
            endcase
        end
    end

    assign cnt_hit_total    = {1'b0, cnt_rd_hit} + {1'b0, cnt_wr_hit};
    assign cnt_miss_total   = {1'b0, cnt_rd_miss} + {1'b0, cnt_wr_miss};
    assign cnt_access_total = {1'b0, cnt_hit_total} + {1'b0, cnt_miss_total};

endmodule

// File: rtl/xlt_cache.sv
module xlt_cache
    import xlt_pkg::*;
#(
    parameter int N        = 8,
    parameter int VPN_W    = 27,
    parameter int ASID_W   = 16,
    parameter int PPN_W    = 28,
    parameter int LVL_W    = 2,
    parameter int LVL_BITS = 9,
    parameter int PTE_W    = 8,
    parameter int OFF_W    = 12,
    parameter int SEQ_W    = 32,
    parameter int CNT_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [VPN_W+OFF_W-1:0]  lk_vaddr,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic                    lk_write,
    input  logic                    lk_hidden,
    input  logic                    ins_valid,
    input  logic [VPN_W-1:0]        ins_vpn,
    input  logic [ASID_W-1:0]       ins_asid,
    input  logic [PPN_W-1:0]        ins_ppn,
    input  logic [LVL_W-1:0]        ins_level,
    input  logic [PTE_W-1:0]        ins_pte,
    input  logic                    fl_valid,
    input  logic [VPN_W-1:0]        fl_vpn,
    input  logic [ASID_W-1:0]       fl_asid,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [PPN_W+OFF_W-1:0]  rsp_paddr,
    output logic [PTE_W-1:0]        rsp_pte,
    output logic [CNT_W-1:0]        cnt_rd_hit,
    output logic [CNT_W-1:0]        cnt_rd_miss,
    output logic [CNT_W-1:0]        cnt_wr_hit,
    output logic [CNT_W-1:0]        cnt_wr_miss,
    output logic [CNT_W:0]          cnt_hit_total,
    output logic [CNT_W:0]          cnt_miss_total,
    output logic [CNT_W+1:0]        cnt_access_total
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;

    typedef logic [IDX_W-1:0] idx_t;

    // slot storage
    logic [N-1:0]              ent_valid;
    logic [N-1:0][VPN_W-1:0]   ent_vpn;
    logic [N-1:0][ASID_W-1:0]  ent_asid;
    logic [N-1:0][LVL_W-1:0]   ent_lvl;
    logic [N-1:0][PPN_W-1:0]   ent_ppn;
    logic [N-1:0][PTE_W-1:0]   ent_pte;
    logic [N-1:0][SEQ_W-1:0]   ent_stamp;
    logic [SEQ_W-1:0]          seq_q;
    logic [SEQ_W-1:0]          seq_next;

    xlt_op_e op_cur;
    xlt_op_e op_q;

    logic [VPN_W-1:0] lk_vpn;
    logic [N-1:0]     lk_hit;
    logic [N-1:0]     ins_hit;
    logic [N-1:0]     fl_hit;
    logic             lk_any;
    logic             ins_any;
    idx_t             lk_idx;
    idx_t             ins_idx;
    idx_t             vic_idx;
    logic [VPN_W-1:0] lk_keep;
    logic [PA_W-1:0]  lk_pa;

    function automatic idx_t first_set(input logic [N-1:0] v);
        idx_t r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i);
        end
        return r;
    endfunction

    assign lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
    assign seq_next = seq_q + 1'b1;

    // three compare banks: lookup, fill key, fence
    xlt_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_W(LVL_W), .LVL_BITS(LVL_BITS)) u_lk_match (
        .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid), .ent_lvl(ent_lvl),
        .q_vpn(lk_vpn), .q_asid(lk_asid), .q_lvl('0),
        .any_vpn(1'b0), .any_asid(1'b0), .same_lvl(1'b0), .hit(lk_hit)
    );

    xlt_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_W(LVL_W), .LVL_BITS(LVL_BITS)) u_ins_match (
        .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid), .ent_lvl(ent_lvl),
        .q_vpn(ins_vpn), .q_asid(ins_asid), .q_lvl(ins_level),
        .any_vpn(1'b0), .any_asid(1'b0), .same_lvl(1'b1), .hit(ins_hit)
    );

    xlt_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_W(LVL_W), .LVL_BITS(LVL_BITS)) u_fl_match (
        .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid), .ent_lvl(ent_lvl),
        .q_vpn(fl_vpn), .q_asid(fl_asid), .q_lvl('0),
        .any_vpn(fl_vpn == '0), .any_asid(fl_asid == '0), .same_lvl(1'b0), .hit(fl_hit)
    );

    xlt_victim #(.N(N), .SEQ_W(SEQ_W)) u_victim (
        .ent_valid(ent_valid), .ent_stamp(ent_stamp), .victim(vic_idx)
    );

    assign lk_any  = |lk_hit;
    assign ins_any = |ins_hit;
    assign lk_idx  = first_set(lk_hit);
    assign ins_idx = first_set(ins_hit);

    // physical address: base OR the virtual bits the page level leaves open
    assign lk_keep = {VPN_W{1'b1}} << (LVL_BITS * int'(ent_lvl[lk_idx]));
    assign lk_pa   = {ent_ppn[lk_idx] | PPN_W'(lk_vpn & ~lk_keep), lk_vaddr[OFF_W-1:0]};

    // operation decode
    always_comb begin
        if (fl_valid)       op_cur = OP_FLUSH;
        else if (ins_valid) op_cur = OP_INSERT;
        else if (lk_valid)  op_cur = OP_LOOKUP;
        else                op_cur = OP_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) op_q <= OP_IDLE;
        else        op_q <= op_cur;
    end

    // slot update per operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_vpn   <= '0;
            ent_asid  <= '0;
            ent_lvl   <= '0;
            ent_ppn   <= '0;
            ent_pte   <= '0;
            ent_stamp <= '0;
            seq_q     <= '0;
        end else begin
            unique case (op_cur)
                OP_FLUSH: begin
                    ent_valid <= ent_valid & ~fl_hit;
                end
                OP_INSERT: begin
                    if (ins_any) begin
                        ent_pte[ins_idx]   <= ins_pte;
                        ent_stamp[ins_idx] <= seq_next;
                    end else begin
                        ent_valid[vic_idx] <= 1'b1;
                        ent_vpn[vic_idx]   <= ins_vpn;
                        ent_asid[vic_idx]  <= ins_asid;
                        ent_lvl[vic_idx]   <= ins_level;
                        ent_ppn[vic_idx]   <= ins_ppn;
                        ent_pte[vic_idx]   <= ins_pte;
                        ent_stamp[vic_idx] <= seq_next;
                    end
                    seq_q <= seq_next;
                end
                OP_LOOKUP: begin
                    if (lk_any && !lk_hidden) begin
                        ent_stamp[lk_idx] <= seq_next;
                        seq_q             <= seq_next;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_pte   <= '0;
        end else begin
            rsp_hit   <= (op_cur == OP_LOOKUP) && lk_any;
            rsp_paddr <= ((op_cur == OP_LOOKUP) && lk_any) ? lk_pa : '0;
            rsp_pte   <= ((op_cur == OP_LOOKUP) && lk_any) ? ent_pte[lk_idx] : '0;
        end
    end

    assign rsp_valid = (op_q == OP_LOOKUP);

    xlt_counters #(.CNT_W(CNT_W)) u_counters (
        .clk(clk), .rst_n(rst_n),
        .count_en((op_cur == OP_LOOKUP) && !lk_hidden),
        .is_write(lk_write), .was_hit(lk_any),
        .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
        .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss),
        .cnt_hit_total(cnt_hit_total), .cnt_miss_total(cnt_miss_total),
        .cnt_access_total(cnt_access_total)
    );

endmodule

// File: rtl/xlt_cache_chk.sv
module xlt_cache_chk #(
    parameter int N      = 8,
    parameter int VPN_W  = 27,
    parameter int ASID_W = 16,
    parameter int PA_W   = 40,
    parameter int PTE_W  = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_hidden,
    input logic              ins_valid,
    input logic              fl_valid,
    input logic [VPN_W-1:0]  fl_vpn,
    input logic [ASID_W-1:0] fl_asid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [PTE_W-1:0]  rsp_pte,
    input logic [CNT_W+1:0]  cnt_access_total,
    input logic [N-1:0]      ent_valid
);

    AST_RSP_FROM_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid && !ins_valid && !fl_valid)); // R3

    AST_HIT_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R1

    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_pte == '0)); // R11

    AST_HIDDEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hidden && !ins_valid && !fl_valid) |=> $stable(cnt_access_total)); // R10

    AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && !lk_hidden && !ins_valid && !fl_valid) |=> $stable(cnt_access_total)); // R9

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_vpn == '0 && fl_asid == '0) |=> (ent_valid == '0)); // R7

    AST_FILL_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !fl_valid) |=> (ent_valid != '0)); // R5

endmodule

bind xlt_cache xlt_cache_chk #(
    .N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PA_W(PPN_W + OFF_W), .PTE_W(PTE_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hidden(lk_hidden),
    .ins_valid(ins_valid), .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte),
    .cnt_access_total(cnt_access_total), .ent_valid(ent_valid)
);

// File: tb/sim_xlt_cache.sv
module sim_xlt_cache;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int VPN_W = 27;
    localparam int PPN_W = 28;
    localparam int OFF_W = 12;
    localparam int LB    = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0, lk_hidden = 0;
    logic [38:0] lk_vaddr = '0;
    logic [15:0] lk_asid = '0;
    logic        ins_valid = 0;
    logic [26:0] ins_vpn = '0;
    logic [15:0] ins_asid = '0;
    logic [27:0] ins_ppn = '0;
    logic [1:0]  ins_level = '0;
    logic [7:0]  ins_pte = '0;
    logic        fl_valid = 0;
    logic [26:0] fl_vpn = '0;
    logic [15:0] fl_asid = '0;
    logic        rsp_valid, rsp_hit;
    logic [39:0] rsp_paddr;
    logic [7:0]  rsp_pte;
    logic [15:0] cnt_rd_hit, cnt_rd_miss, cnt_wr_hit, cnt_wr_miss;
    logic [16:0] cnt_hit_total, cnt_miss_total;
    logic [17:0] cnt_access_total;

    int checks = 0;
    int errors = 0;

    // bench model of the slots
    bit          m_ok[N];
    logic [26:0] m_vpn[N];
    logic [15:0] m_asid[N];
    int          m_lvl[N];
    logic [27:0] m_ppn[N];
    logic [7:0]  m_pte[N];
    int unsigned m_stamp[N];
    int unsigned m_seq;
    logic [15:0] m_rh, m_rm, m_wh, m_wm;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlt_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_write(lk_write), .lk_hidden(lk_hidden),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_asid(ins_asid),
        .ins_ppn(ins_ppn), .ins_level(ins_level), .ins_pte(ins_pte),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte),
        .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
        .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss),
        .cnt_hit_total(cnt_hit_total), .cnt_miss_total(cnt_miss_total),
        .cnt_access_total(cnt_access_total)
    );

    function automatic logic [26:0] keep_of(int lvl);
        return {VPN_W{1'b1}} << (LB * lvl);
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(logic [26:0] v, logic [15:0] a);
        for (int i = 0; i < N; i++)
            if (m_ok[i] && m_asid[i] == a && ((m_vpn[i] ^ v) & keep_of(m_lvl[i])) == '0) return i;
        return -1;
    endfunction

    task automatic m_insert();
        int ix = -1;
        for (int i = 0; i < N; i++)
            if (ix < 0 && m_ok[i] && m_asid[i] == ins_asid && m_lvl[i] == int'(ins_level) &&
                ((m_vpn[i] ^ ins_vpn) & keep_of(m_lvl[i])) == '0) ix = i;
        m_seq++;
        if (ix >= 0) begin
            m_pte[ix] = ins_pte;
            m_stamp[ix] = m_seq;
        end else begin
            for (int i = 0; i < N; i++) if (ix < 0 && !m_ok[i]) ix = i;
            if (ix < 0) begin
                ix = 0;
                for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[ix]) ix = i;
            end
            m_ok[ix] = 1; m_vpn[ix] = ins_vpn; m_asid[ix] = ins_asid;
            m_lvl[ix] = int'(ins_level); m_ppn[ix] = ins_ppn; m_pte[ix] = ins_pte;
            m_stamp[ix] = m_seq;
        end
    endtask

    task automatic m_flush();
        for (int i = 0; i < N; i++)
            if (m_ok[i] && (fl_vpn == '0 || ((m_vpn[i] ^ fl_vpn) & keep_of(m_lvl[i])) == '0) &&
                (fl_asid == '0 || m_asid[i] == fl_asid)) m_ok[i] = 0;
    endtask

    // one operation: predict, clock, compare, release inputs
    task automatic tick(string tag);
        logic e_rv = 0, e_hit = 0;
        logic [39:0] e_pa = '0;
        logic [7:0]  e_pte = '0;
        if (fl_valid) m_flush();
        else if (ins_valid) m_insert();
        else if (lk_valid) begin
            int ix = m_find(lk_vaddr[38:12], lk_asid);
            e_rv = 1;
            if (ix >= 0) begin
                e_hit = 1;
                e_pte = m_pte[ix];
                e_pa = {m_ppn[ix] | 28'(lk_vaddr[38:12] & ~keep_of(m_lvl[ix])), lk_vaddr[11:0]};
            end
            if (!lk_hidden) begin
                if (lk_write) begin if (ix >= 0) m_wh++; else m_wm++; end
                else begin if (ix >= 0) m_rh++; else m_rm++; end
                if (ix >= 0) begin m_seq++; m_stamp[ix] = m_seq; end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        if (e_rv) begin
            check(tag, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
            check(tag, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
            check(tag, "rsp_pte", 64'(rsp_pte), 64'(e_pte));
        end
        check("R9", "rd_hit", 64'(cnt_rd_hit), 64'(m_rh));
        check("R9", "rd_miss", 64'(cnt_rd_miss), 64'(m_rm));
        check("R9", "wr_hit", 64'(cnt_wr_hit), 64'(m_wh));
        check("R9", "wr_miss", 64'(cnt_wr_miss), 64'(m_wm));
        check("R9", "access_total", 64'(cnt_access_total), 64'(m_rh) + m_rm + m_wh + m_wm);
        check("R9", "hit_total", 64'(cnt_hit_total), 64'(m_rh) + m_wh);
        lk_valid = 0; ins_valid = 0; fl_valid = 0; lk_hidden = 0; lk_write = 0;
    endtask

    task automatic look(logic [26:0] v, logic [15:0] a, logic wr, logic hid, string tag);
        lk_valid = 1; lk_vaddr = {v, 12'($urandom_range(0, 4095))};
        lk_asid = a; lk_write = wr; lk_hidden = hid;
        tick(tag);
    endtask

    task automatic fill(logic [26:0] v, logic [15:0] a, logic [27:0] p, int l, logic [7:0] pt, string tag);
        ins_valid = 1; ins_vpn = v; ins_asid = a; ins_ppn = p; ins_level = 2'(l); ins_pte = pt;
        tick(tag);
    endtask

    task automatic fence(logic [26:0] v, logic [15:0] a, string tag);
        fl_valid = 1; fl_vpn = v; fl_asid = a;
        tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd7519));
        m_seq = 0; m_rh = 0; m_rm = 0; m_wh = 0; m_wm = 0;
        for (int i = 0; i < N; i++) begin m_ok[i] = 0; m_stamp[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        check("R11", "rsp_valid", 64'(rsp_valid), 0);
        check("R11", "access_total", 64'(cnt_access_total), 0);
        look(27'h100, 16'd5, 0, 0, "R11");

        // R1 basic hit and tag mismatch
        fill(27'h100, 16'd5, 28'h1234, 0, 8'hCF, "R1");
        look(27'h100, 16'd5, 0, 0, "R1");
        look(27'h100, 16'd6, 1, 0, "R1");
        // R2 superpages
        fill(27'h400, 16'd5, 28'h200, 1, 8'h5B, "R2");
        look(27'h5A7, 16'd5, 1, 0, "R2");
        fill(27'h80000, 16'd5, 28'h40000, 2, 8'h17, "R2");
        look(27'h8ABCD, 16'd5, 0, 0, "R2");
        // R4 refill same key updates permissions only
        fill(27'h100, 16'd5, 28'h1234, 0, 8'h3A, "R4");
        look(27'h100, 16'd5, 0, 0, "R4");

        // R6 / R10: fill all, hidden touch, visible touch, then evict
        fence(27'h0, 16'h0, "R7");
        look(27'h100, 16'd5, 0, 0, "R7");
        for (int k = 1; k <= N; k++) fill(27'(k), 16'd7, 28'(k + 32), 0, 8'(k), "R6");
        look(27'h1, 16'd7, 0, 1, "R10");
        look(27'h2, 16'd7, 1, 0, "R6");
        fill(27'h9, 16'd7, 28'h99, 0, 8'h99, "R6");
        look(27'h1, 16'd7, 0, 0, "R6");
        look(27'h2, 16'd7, 0, 0, "R6");
        // R5 fenced slot is reused before eviction
        fence(27'h3, 16'd7, "R7");
        fill(27'hA, 16'd7, 28'hAA, 0, 8'hAA, "R5");
        for (int k = 2; k <= 10; k++) look(27'(k), 16'd7, 0, 0, "R5");
        // R7 tag-only and address-only fences
        fill(27'h4, 16'd8, 28'h444, 0, 8'h44, "R7");
        fence(27'h0, 16'd7, "R7");
        look(27'h5, 16'd7, 0, 0, "R7");
        look(27'h4, 16'd8, 0, 0, "R7");
        fill(27'h4, 16'd9, 28'h555, 0, 8'h55, "R7");
        fence(27'h4, 16'h0, "R7");
        look(27'h4, 16'd8, 0, 0, "R7");
        look(27'h4, 16'd9, 0, 0, "R7");
        // R8 fence inside a superpage
        fill(27'h600, 16'd9, 28'h800, 1, 8'h66, "R8");
        fence(27'h6FF, 16'd9, "R8");
        look(27'h600, 16'd9, 0, 0, "R8");
        // R3 priority
        fill(27'h20, 16'd3, 28'h20, 0, 8'h20, "R3");
        fl_valid = 1; fl_vpn = 27'h20; fl_asid = 16'd3;
        lk_valid = 1; lk_vaddr = {27'h20, 12'h0}; lk_asid = 16'd3;
        tick("R3");
        ins_valid = 1; ins_vpn = 27'h21; ins_asid = 16'd3; ins_ppn = 28'h21; ins_level = 0; ins_pte = 8'h21;
        lk_valid = 1; lk_vaddr = {27'h21, 12'h0}; lk_asid = 16'd3;
        tick("R3");
        look(27'h21, 16'd3, 0, 0, "R3");
        look(27'h20, 16'd3, 1, 0, "R3");

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            logic [26:0] v = 27'(($urandom_range(0, 1) << 18) | ($urandom_range(0, 3) << 9) | $urandom_range(0, 5));
            logic [15:0] a = 16'($urandom_range(1, 3));
            if (r < 4) begin
                fence(($urandom_range(0, 1) == 0) ? 27'h0 : v, ($urandom_range(0, 1) == 0) ? 16'h0 : a, "R7");
            end else if (r < 30) begin
                int q = $urandom_range(0, 99);
                int l = (q < 80) ? 0 : ((q < 95) ? 1 : 2);
                fill(v, a, 28'($urandom()) & ({PPN_W{1'b1}} << (LB * l)), l, 8'($urandom()), "R6");
            end else begin
                look(v, a, 1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0), "R1");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule